// File: doc/BRIEF.md
# Linked-Descriptor Two-Dimensional Copy Engine

This block is a single-channel memory-to-memory copy engine. Software places a chain of control blocks in memory and pulses a start input with the address of the first one. The engine reads each six-word control block through a 32-bit master port, then moves data in 4-byte beats from a source address to a destination address. It follows the next-block pointer until that pointer is zero.

Each block runs in one of two modes. In linear mode it moves one run of bytes. In two-dimensional mode it moves several rows of equal length, and between rows it adds a signed stride to each address. Per block, the source read or the destination write can be suppressed, and each address can either step by 4 after every beat or stay fixed. When a block finishes, the engine raises a sticky end-of-block flag and, if the block asks for it, a sticky interrupt. Software clears these flags with dedicated clear inputs. The current control-block fields and the live addresses and remaining length are visible as read-only outputs.

The memory port uses a valid/ready request channel that carries reads and writes. Read data returns on a separate response strobe, and only one request is outstanding at a time.

Top module: `desc_dma2d`

## Requirements
- R1: A control block at address A is read as six words at A+0, A+4, A+8, A+12, A+16, A+20, in that order, and they are taken as info, source address, destination address, length, stride and next-block address.
- R2: Info bit positions: bit 0 enables the interrupt, bit 1 selects two-dimensional mode, bit 4 steps the destination, bit 7 suppresses destination writes, bit 8 steps the source, bit 11 suppresses source reads.
- R3: In linear mode the block is a single row whose byte count is the full 32-bit length word, moved as count/4 beats, with no stride applied.
- R4: In two-dimensional mode the row count is length bits 29:16 and the row size in bytes is length bits 15:0. The row size is reloaded at the start of each row. The signed 16-bit source stride (stride bits 15:0) and destination stride (stride bits 31:16) are added after every row except the last. A row count of zero moves no data.
- R5: With source suppression set, no read is issued for data and the written word is zero.
- R6: With destination suppression set, no write is issued.
- R7: After each beat, each address advances by 4 only if its own step bit is set, and otherwise stays unchanged.
- R8: After each beat the visible remaining length is updated. In linear mode it holds the remaining bytes. In two-dimensional mode it holds the current row count in bits 31:16 and the bytes left in the row in bits 15:0.
- R9: At the end of a block the end flag is set, the interrupt is set if info bit 0 is set, and the current block address takes the next-block pointer. A pointer of zero ends the chain. The clear inputs reset the flags.
- R10: A start while the channel enable is low does nothing. Enable is checked at each block boundary, so clearing it lets the current block finish and then stops the chain with the current block address at the next pointer.
- R11: A start pulse while a chain is running is ignored.
- R12: A request holds its address, direction and data stable until accepted, and transfers happen in strict program order.
- R13: After reset the engine is idle with no request pending, both flags clear, and the current block address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable, checked at start and at each block boundary |
| start | input | 1 | One-cycle start pulse |
| start_addr | input | 32 | Address of the first control block |
| clr_end | input | 1 | Clears the end-of-block flag |
| clr_irq | input | 1 | Clears the interrupt flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Read data |
| busy | output | 1 | Chain in progress |
| end_flag | output | 1 | Sticky end-of-block flag |
| irq | output | 1 | Sticky interrupt flag |
| cur_cb | output | 32 | Current control-block address |
| cur_info | output | 32 | Info word of the current block |
| cur_src | output | 32 | Live source address |
| cur_dst | output | 32 | Live destination address |
| cur_len | output | 32 | Live remaining length |
| cur_stride | output | 32 | Stride word of the current block |
| cur_next | output | 32 | Next-block pointer of the current block |

## Verification
The assertions assume a well-behaved memory. It raises the read response strobe only for a read that has been accepted and not yet answered, and it never returns a response while the engine is idle. Under that assumption, the request-hold, idle-quiet and interrupt-source properties reflect only the engine's own sequencing. The bench memory keeps to this. It answers each accepted read exactly once, one or two cycles later, and it varies ready in a fixed rhythm so that stalls fall on fetch, read and write requests alike. All descriptors and buffers are word-aligned, and lengths are multiples of four.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CB_WORDS = 6;
    localparam int unsigned IDX_W    = $clog2(CB_WORDS);

    // info word bit positions
    localparam int unsigned INFO_IRQ_EN  = 0;
    localparam int unsigned INFO_TWO_D   = 1;
    localparam int unsigned INFO_DST_INC = 4;
    localparam int unsigned INFO_DST_IGN = 7;
    localparam int unsigned INFO_SRC_INC = 8;
    localparam int unsigned INFO_SRC_IGN = 11;

    typedef enum logic [3:0] {
        S_IDLE = 4'd0,
        S_FREQ = 4'd1,
        S_FRSP = 4'd2,
        S_ROW  = 4'd3,
        S_RREQ = 4'd4,
        S_RRSP = 4'd5,
        S_WREQ = 4'd6,
        S_STEP = 4'd7,
        S_REND = 4'd8,
        S_BLK  = 4'd9
    } eng_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] info;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] stride;
        logic [WORD_W-1:0] next;
    } cblk_t;

    typedef struct packed {
        eng_state_e        st;
        logic [IDX_W-1:0]  widx;
        logic [WORD_W-1:0] cb;
        cblk_t             desc;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] len;
        logic [15:0]       rows;
        logic [WORD_W-1:0] xrem;
        logic [WORD_W-1:0] data;
        logic              end_f;
        logic              irq_f;
    } eng_t;

endpackage

// File: rtl/dma2d_geom.sv
module dma2d_geom #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned HALF_W  = 16,
    parameter int unsigned ROWC_W  = 14
) (
    input  logic              two_d_i,
    input  logic [WORD_W-1:0] len_i,
    input  logic [WORD_W-1:0] stride_i,
    output logic [HALF_W-1:0] rows_o,
    output logic [WORD_W-1:0] row_bytes_o,
    output logic [WORD_W-1:0] src_stride_o,
    output logic [WORD_W-1:0] dst_stride_o
);
    localparam int unsigned PAD_W = HALF_W - ROWC_W;

    always_comb begin
        if (two_d_i) begin
            rows_o       = {{PAD_W{1'b0}}, len_i[HALF_W +: ROWC_W]};
            row_bytes_o  = {{(WORD_W-HALF_W){1'b0}}, len_i[HALF_W-1:0]};
            src_stride_o = {{(WORD_W-HALF_W){stride_i[HALF_W-1]}}, stride_i[HALF_W-1:0]};
            dst_stride_o = {{(WORD_W-HALF_W){stride_i[WORD_W-1]}}, stride_i[WORD_W-1:HALF_W]};
        end else begin
            rows_o       = HALF_W'(1);
            row_bytes_o  = len_i;
            src_stride_o = '0;
            dst_stride_o = '0;
        end
    end
endmodule

// File: rtl/dma2d_addr_adv.sv
module dma2d_addr_adv #(
    parameter int unsigned AW   = 32,
    parameter int unsigned STEP = 4
) (
    input  logic [AW-1:0] addr_i,
    input  logic          inc_i,
    input  logic [AW-1:0] stride_i,
    output logic [AW-1:0] beat_o,
    output logic [AW-1:0] row_o
);
    always_comb begin
        beat_o = inc_i ? (addr_i + AW'(STEP)) : addr_i;
        row_o  = addr_i + stride_i;
    end
endmodule

// File: rtl/desc_dma2d.sv
module desc_dma2d
    import dma2d_pkg::*;
#(
    parameter int unsigned BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              start,
    input  logic [WORD_W-1:0] start_addr,
    input  logic              clr_end,
    input  logic              clr_irq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              busy,
    output logic              end_flag,
    output logic              irq,
    output logic [WORD_W-1:0] cur_cb,
    output logic [WORD_W-1:0] cur_info,
    output logic [WORD_W-1:0] cur_src,
    output logic [WORD_W-1:0] cur_dst,
    output logic [WORD_W-1:0] cur_len,
    output logic [WORD_W-1:0] cur_stride,
    output logic [WORD_W-1:0] cur_next
);
    localparam logic [IDX_W-1:0] CB_LAST  = IDX_W'(CB_WORDS - 1);
    localparam logic [WORD_W-1:0] BEAT_W  = WORD_W'(BEAT_BYTES);
    localparam int unsigned N_ADR = 2;   // 0 = source, 1 = destination

    eng_t q, d;

    // descriptor geometry
    logic              two_d;
    logic [15:0]       g_rows;
    logic [WORD_W-1:0] g_row_bytes, g_src_stride, g_dst_stride;

    assign two_d = q.desc.info[INFO_TWO_D];

    dma2d_geom #(.WORD_W(WORD_W), .HALF_W(16), .ROWC_W(14)) u_geom (
        .two_d_i      (two_d),
        .len_i        (q.desc.len),
        .stride_i     (q.desc.stride),
        .rows_o       (g_rows),
        .row_bytes_o  (g_row_bytes),
        .src_stride_o (g_src_stride),
        .dst_stride_o (g_dst_stride)
    );

    // address steppers
    logic [N_ADR-1:0][WORD_W-1:0] adv_base, adv_stride, adv_beat, adv_row;
    logic [N_ADR-1:0]             adv_inc;

    assign adv_base[0]   = q.src;
    assign adv_base[1]   = q.dst;
    assign adv_stride[0] = g_src_stride;
    assign adv_stride[1] = g_dst_stride;
    assign adv_inc[0]    = q.desc.info[INFO_SRC_INC];
    assign adv_inc[1]    = q.desc.info[INFO_DST_INC];

    for (genvar k = 0; k < N_ADR; k++) begin : g_adv
        dma2d_addr_adv #(.AW(WORD_W), .STEP(BEAT_BYTES)) u_adv (
            .addr_i   (adv_base[k]),
            .inc_i    (adv_inc[k]),
            .stride_i (adv_stride[k]),
            .beat_o   (adv_beat[k]),
            .row_o    (adv_row[k])
        );
    end

    logic              src_ign, dst_ign;
    logic [WORD_W-1:0] xrem_n;
    logic [15:0]       rows_n;
    logic [WORD_W-1:0] fetch_addr;

    assign src_ign    = q.desc.info[INFO_SRC_IGN];
    assign dst_ign    = q.desc.info[INFO_DST_IGN];
    assign xrem_n     = (q.xrem < BEAT_W) ? '0 : (q.xrem - BEAT_W);
    assign rows_n     = q.rows - 16'd1;
    assign fetch_addr = q.cb + WORD_W'({q.widx, 2'b00});

    // next-state logic
    always_comb begin
        d = q;
        if (clr_end) d.end_f = 1'b0;
        if (clr_irq) d.irq_f = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (start && chan_en) begin
                    d.cb = start_addr;
                    if (start_addr != '0) begin
                        d.st   = S_FREQ;
                        d.widx = '0;
                    end
                end
            end
            S_FREQ: begin
                if (mem_req_ready) d.st = S_FRSP;
            end
            S_FRSP: begin
                if (mem_rsp_valid) begin
                    unique case (q.widx)
                        IDX_W'(0): d.desc.info   = mem_rsp_rdata;
                        IDX_W'(1): d.desc.src    = mem_rsp_rdata;
                        IDX_W'(2): d.desc.dst    = mem_rsp_rdata;
                        IDX_W'(3): d.desc.len    = mem_rsp_rdata;
                        IDX_W'(4): d.desc.stride = mem_rsp_rdata;
                        default:   d.desc.next   = mem_rsp_rdata;
                    endcase
                    if (q.widx == CB_LAST) begin
                        // fields 0..4 already registered; geometry is valid
                        d.src  = q.desc.src;
                        d.dst  = q.desc.dst;
                        d.len  = q.desc.len;
                        d.rows = g_rows;
                        d.xrem = g_row_bytes;
                        d.st   = S_ROW;
                    end else begin
                        d.widx = q.widx + IDX_W'(1);
                        d.st   = S_FREQ;
                    end
                end
            end
            S_ROW: begin
                if (q.rows == '0) begin
                    d.st = S_BLK;
                end else if (q.xrem == '0) begin
                    d.st = S_REND;
                end else if (!src_ign) begin
                    d.st = S_RREQ;
                end else begin
                    d.data = '0;
                    d.st   = dst_ign ? S_STEP : S_WREQ;
                end
            end
            S_RREQ: begin
                if (mem_req_ready) d.st = S_RRSP;
            end
            S_RRSP: begin
                if (mem_rsp_valid) begin
                    d.data = mem_rsp_rdata;
                    d.st   = dst_ign ? S_STEP : S_WREQ;
                end
            end
            S_WREQ: begin
                if (mem_req_ready) d.st = S_STEP;
            end
            S_STEP: begin
                d.src  = adv_beat[0];
                d.dst  = adv_beat[1];
                d.xrem = xrem_n;
                d.len  = two_d ? {q.rows, xrem_n[15:0]} : xrem_n;
                d.st   = S_ROW;
            end
            S_REND: begin
                d.rows = rows_n;
                if (rows_n != '0) begin
                    d.src  = adv_row[0];
                    d.dst  = adv_row[1];
                    d.xrem = g_row_bytes;
                    d.st   = S_ROW;
                end else begin
                    d.st = S_BLK;
                end
            end
            S_BLK: begin
                d.end_f = 1'b1;
                if (q.desc.info[INFO_IRQ_EN]) d.irq_f = 1'b1;
                d.cb = q.desc.next;
                if ((q.desc.next != '0) && chan_en) begin
                    d.st   = S_FREQ;
                    d.widx = '0;
                end else begin
                    d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // request channel
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        unique case (q.st)
            S_FREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = fetch_addr;
            end
            S_RREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.src;
            end
            S_WREQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = q.dst;
            end
            default: ;
        endcase
    end

    assign mem_req_wdata = q.data;
    assign busy          = (q.st != S_IDLE);
    assign end_flag      = q.end_f;
    assign irq           = q.irq_f;
    assign cur_cb        = q.cb;
    assign cur_info      = q.desc.info;
    assign cur_src       = q.src;
    assign cur_dst       = q.dst;
    assign cur_len       = q.len;
    assign cur_stride    = q.desc.stride;
    assign cur_next      = q.desc.next;

endmodule

// File: rtl/desc_dma2d_chk.sv
module desc_dma2d_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        chan_en,
    input logic        busy,
    input logic        irq,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic [31:0] cur_info
);
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    assert_no_write_ign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> !cur_info[7]);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> cur_info[0]);

    assert_disabled_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !chan_en) |=> !busy);
endmodule

bind desc_dma2d desc_dma2d_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .chan_en       (chan_en),
    .busy          (busy),
    .irq           (irq),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .cur_info      (cur_info)
);

// File: tb/desc_dma2d_tb_top.sv
`timescale 1ns/1ps
module desc_dma2d_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        clr_end = 1'b0;
    logic        clr_irq = 1'b0;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        busy, end_flag, irq;
    logic [31:0] cur_cb, cur_info, cur_src, cur_dst, cur_len, cur_stride, cur_next;

    always #10 clk = ~clk;   // 50 MHz

    desc_dma2d dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start),
        .start_addr(start_addr), .clr_end(clr_end), .clr_irq(clr_irq),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .busy(busy), .end_flag(end_flag),
        .irq(irq), .cur_cb(cur_cb), .cur_info(cur_info), .cur_src(cur_src),
        .cur_dst(cur_dst), .cur_len(cur_len), .cur_stride(cur_stride),
        .cur_next(cur_next)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } txn_t;

    txn_t        expq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] mem  [0:1023];
    logic [31:0] mexp [0:1023];
    logic [31:0] e_src, e_dst, e_len, e_cb, e_info;
    bit          e_end = 0;
    bit          e_irq = 0;

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put(logic [31:0] a, logic [31:0] v);
        mem[a[11:2]]  = v;
        mexp[a[11:2]] = v;
    endtask

    task automatic put_cb(logic [31:0] a, logic [31:0] info, logic [31:0] src,
                          logic [31:0] dst, logic [31:0] len, logic [31:0] strd,
                          logic [31:0] nxt);
        put(a, info); put(a + 4, src); put(a + 8, dst);
        put(a + 12, len); put(a + 16, strd); put(a + 20, nxt);
    endtask

    task automatic push(bit we, logic [31:0] a, logic [31:0] dv, string tag);
        txn_t t;
        t.we = we; t.addr = a; t.data = dv; t.tag = tag;
        expq.push_back(t);
    endtask

    // driver-side reference walk of the chain
    task automatic model(logic [31:0] cb0, int max_blocks);
        logic [31:0] cb, f[6], s, dd, l, rb, ss, ds, x, dv;
        logic [15:0] r;
        bit two;
        int nb;
        cb = cb0; nb = 0;
        while (cb != 0 && nb < max_blocks) begin
            for (int w = 0; w < 6; w++) begin
                push(0, cb + 32'(4 * w), '0, "R1 fetch");
                f[w] = mexp[(cb[11:2]) + 10'(w)];
            end
            two = f[0][1];
            r   = two ? {2'b00, f[3][29:16]} : 16'd1;
            rb  = two ? {16'h0, f[3][15:0]} : f[3];
            ss  = two ? {{16{f[4][15]}}, f[4][15:0]} : '0;
            ds  = two ? {{16{f[4][31]}}, f[4][31:16]} : '0;
            s = f[1]; dd = f[2]; l = f[3];
            while (r != 0) begin
                x = rb;
                while (x != 0) begin
                    if (f[0][11]) dv = '0;
                    else begin
                        dv = mexp[s[11:2]];
                        push(0, s, '0, "R7 source read");
                    end
                    if (!f[0][7]) begin
                        push(1, dd, dv, f[0][11] ? "R5 zero write" : "R4 data write");
                        mexp[dd[11:2]] = dv;
                    end
                    if (f[0][8]) s = s + 4;
                    if (f[0][4]) dd = dd + 4;
                    x = (x < 4) ? '0 : x - 4;
                    l = two ? {r, x[15:0]} : x;
                end
                r = r - 1;
                if (r != 0) begin
                    s = s + ss;
                    dd = dd + ds;
                end
            end
            e_end = 1;
            if (f[0][0]) e_irq = 1;
            e_info = f[0]; e_src = s; e_dst = dd; e_len = l;
            cb = f[5];
            nb++;
        end
        e_cb = cb;
    endtask

    // memory model and scoreboard monitor
    int          tick = 0;
    bit          rd_pend = 0;
    int          rd_wait = 0;
    logic [31:0] rd_addr = '0;

    always @(negedge clk) begin
        txn_t t;
        tick++;
        mem_rsp_valid = 1'b0;
        if (rd_pend) begin
            if (rd_wait == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem[rd_addr[11:2]];
                rd_pend = 0;
            end else rd_wait--;
        end
        mem_req_ready = (tick % 3) != 1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            n_chk++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R12 unexpected request: actual we=%0d addr %h expected none",
                         mem_req_write, mem_req_addr);
            end else begin
                t = expq.pop_front();
                if (t.we != mem_req_write || t.addr !== mem_req_addr ||
                    (t.we && t.data !== mem_req_wdata)) begin
                    n_bad++;
                    $display("FAIL %s: actual we=%0d addr %h data %h expected we=%0d addr %h data %h",
                             t.tag, mem_req_write, mem_req_addr, mem_req_wdata,
                             t.we, t.addr, t.data);
                end
            end
            if (!mem_req_write) begin
                rd_pend = 1; rd_wait = tick % 2; rd_addr = mem_req_addr;
            end else begin
                mem[mem_req_addr[11:2]] = mem_req_wdata;
            end
        end
    end

    task automatic pulse_start(logic [31:0] a);
        @(negedge clk); start = 1'b1; start_addr = a;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_end = 1'b1; clr_irq = 1'b1;
        @(negedge clk); clr_end = 1'b0; clr_irq = 1'b0;
        e_end = 0; e_irq = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic final_chk(string tag);
        check32(tag, "R9 busy", 32'(busy), 32'd0);
        check32(tag, "R9 end_flag", 32'(end_flag), 32'(e_end));
        check32(tag, "R2 irq", 32'(irq), 32'(e_irq));
        check32(tag, "R7 cur_src", cur_src, e_src);
        check32(tag, "R7 cur_dst", cur_dst, e_dst);
        check32(tag, "R8 cur_len", cur_len, e_len);
        check32(tag, "R9 cur_cb", cur_cb, e_cb);
        check32(tag, "R1 cur_info", cur_info, e_info);
        check32(tag, "R12 pending expected traffic", 32'(expq.size()), 32'd0);
    endtask

    task automatic run(logic [31:0] cb, string tag);
        clear_flags();
        model(cb, 1000);
        pulse_start(cb);
        wait_idle();
        final_chk(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 32'h5A00_0000 + 32'(i) * 32'h0001_0007;
            mexp[i] = mem[i];
        end
        // descriptors
        put_cb(32'h100, 32'h0000_0111, 32'h400, 32'h800, 32'd16, 32'h0, 32'h0);
        put_cb(32'h140, 32'h0000_0112, 32'h500, 32'h900, 32'h0003_0008, 32'hFFFC_0008, 32'h0);
        put_cb(32'h160, 32'h0000_0901, 32'h600, 32'hA00, 32'd12, 32'h0, 32'h0);
        put_cb(32'h1A0, 32'h0000_0190, 32'h480, 32'hA40, 32'd8, 32'h0, 32'h0);
        put_cb(32'h180, 32'h0000_0110, 32'h620, 32'hB00, 32'd8, 32'h0, 32'h1C0);
        put_cb(32'h1C0, 32'h0000_0111, 32'h700, 32'hB40, 32'd4, 32'h0, 32'h0);
        put_cb(32'h200, 32'h0000_0113, 32'h440, 32'hC00, 32'h0000_0010, 32'h0, 32'h0);

        repeat (4) @(negedge clk);
        // R13 reset state, sampled while reset is held
        check32("R13", "busy", 32'(busy), 32'd0);
        check32("R13", "req_valid", 32'(mem_req_valid), 32'd0);
        check32("R13", "end_flag", 32'(end_flag), 32'd0);
        check32("R13", "irq", 32'(irq), 32'd0);
        check32("R13", "cur_cb", cur_cb, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(32'h100, "R3 linear");          // R3, R7, R2
        run(32'h140, "R4 2D strides");      // R4, R8
        run(32'h160, "R5 src ignore");      // R5, fixed destination
        run(32'h1A0, "R6 dst ignore");      // R6
        run(32'h200, "R4 zero rows");       // R4 corner
        run(32'h180, "R9 chain");           // R9

        // R10 enable dropped mid-block: first block completes, chain stops
        clear_flags();
        model(32'h180, 1);
        pulse_start(32'h180);
        repeat (3) @(negedge clk);
        chan_en = 1'b0;
        wait_idle();
        final_chk("R10 enable drop");
        chan_en = 1'b1;

        // R9 clear inputs
        clear_flags();
        check32("R9", "end after clear", 32'(end_flag), 32'd0);
        check32("R9", "irq after clear", 32'(irq), 32'd0);

        // R10 start with enable low does nothing
        chan_en = 1'b0;
        pulse_start(32'h100);
        repeat (20) @(negedge clk);
        check32("R10", "busy with enable low", 32'(busy), 32'd0);
        check32("R10", "cur_cb unchanged", cur_cb, 32'h1C0);
        chan_en = 1'b1;

        // R11 start while running is ignored
        clear_flags();
        model(32'h100, 1000);
        pulse_start(32'h100);
        repeat (4) @(negedge clk);
        pulse_start(32'h140);
        wait_idle();
        final_chk("R11 restart ignored");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule